// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and a two-digit-year calendar in seven packed-BCD byte registers. A one-cycle tick input, pulsed once per second by an external divider, advances the seconds. A wrap of one field carries into the next: seconds, then minutes, hours, date, month and year. A day-of-week counter advances on every date rollover. Month lengths come from the current month and year. February gains its 29th day in every year whose two-digit value is a multiple of four.

A host sets any register through a one-cycle parallel load port. The port takes a register index and a data byte. All seven registers are always visible as separate output bytes. The hour register carries a mode bit that selects 24-hour counting or 12-hour counting with an AM/PM flag.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read seconds 00h, minutes 00h, hours 00h, date 01h, month 01h, year 00h and day of week 00h.
- R2: Seconds and minutes count in BCD from 00 to 59. A tick with seconds at 59 gives 00 and advances minutes. Minutes at 59 then also wrap to 00 and advance the hour.
- R3: With hour bit 7 set (24-hour mode), hours count 00 to 23 in bits 5:0. An advance from 23 gives 80h and starts a new day. Bit 7 changes only by a load.
- R4: With hour bit 7 clear (12-hour mode), hours count 1 to 12 in bits 4:0, and bit 5 is the PM flag (1 = PM). The count goes from 12 to 01 with the flag kept, and from 11 to 12 with the flag toggled. Only 11 PM to 12 AM starts a new day.
- R5: Day 31 ends January, March, May, July, August, October and December. Day 30 ends April, June, September and November. The next date is then 01 and the month advances.
- R6: February ends after day 29 when the year value is divisible by 4, including year 00. In every other year it ends after day 28.
- R7: Month 12 wraps to 01 and advances the year. The year counts in BCD from 00 to 99 and wraps to 00.
- R8: Day of week advances by one at each new day and wraps from 6 to 0.
- R9: A load strobe writes the data byte into the register at the given index: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week. Reserved bits are forced to zero. The kept masks are 7Fh for seconds and minutes, BFh for hours, 3Fh for date, 1Fh for month, FFh for year and 07h for day of week.
- R10: A tick in the same cycle as a load has no effect on any register.
- R11: With no tick and no load, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle advance pulse, one per second |
| ld_stb_i | input | 1 | Load strobe |
| ld_idx_i | input | 3 | Index of the register to load |
| ld_data_i | input | 8 | Load data byte |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, with the mode bit and the PM flag |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| wday_o | output | 8 | Day of week, 0 to 6 |

## Verification
Every register changes at the first clock edge after a tick or a load. A full carry chain from seconds to year also settles within that one edge, because the carries are combinational. The bench drives its inputs just after a falling edge and holds them for one cycle. It samples the outputs at the next falling edge, so each load or tick is checked exactly one register stage later. Hold and ignored-tick cases are checked at the same point, after cycles in which a wrong design would have changed a register.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    IDX_SEC   = 3'd0,
    IDX_MIN   = 3'd1,
    IDX_HOUR  = 3'd2,
    IDX_DATE  = 3'd3,
    IDX_MONTH = 3'd4,
    IDX_YEAR  = 3'd5,
    IDX_WDAY  = 3'd6
  } reg_idx_e;

  // Bits kept on a host write, per register index.
  function automatic logic [7:0] write_mask(input int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2:       return 8'hBF;
      3:       return 8'h3F;
      4:       return 8'h1F;
      5:       return 8'hFF;
      6:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [7:0] v);
    logic [7:0] t;
    logic [7:0] u;
    t = v / 8'd10;
    u = v - (t * 8'd10);
    return {t[3:0], u[3:0]};
  endfunction

  // Increment a BCD value, returning 'first' once 'last' is reached or passed.
  function automatic logic [7:0] bcd_step(input logic [7:0] b, input logic [7:0] last,
                                          input logic [7:0] first);
    logic [7:0] n;
    n = bcd_to_bin(b);
    if (n >= last) return bin_to_bcd(first);
    return bin_to_bcd(n + 8'd1);
  endfunction

  function automatic logic is_leap(input logic [7:0] year_bcd);
    logic [7:0] y;
    y = bcd_to_bin(year_bcd);
    return (y[1:0] == 2'b00);
  endfunction

  // Last day of a month, binary.
  function automatic logic [7:0] month_days(input logic [7:0] month_bcd,
                                            input logic [7:0] year_bcd);
    case (bcd_to_bin(month_bcd))
      8'd2:                   return is_leap(year_bcd) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                return 8'd31;
    endcase
  endfunction

  // 24-hour advance; result keeps the mode bit set.
  function automatic logic [7:0] hour24_next(input logic [7:0] hour);
    logic [7:0] s;
    s = bcd_step({2'b00, hour[5:0]}, 8'd23, 8'd0);
    return {2'b10, s[5:0]};
  endfunction

  // 12-hour advance; bit 5 is the PM flag, result keeps the mode bit clear.
  function automatic logic [7:0] hour12_next(input logic [7:0] hour);
    logic [7:0] h;
    logic [7:0] s;
    logic       pm;
    h  = bcd_to_bin({3'b000, hour[4:0]});
    pm = hour[5];
    if (h >= 8'd12) begin
      s = 8'h01;
    end else if (h == 8'd11) begin
      s  = 8'h12;
      pm = ~pm;
    end else begin
      s = bin_to_bcd(h + 8'd1);
    end
    return {2'b00, pm, s[4:0]};
  endfunction

endpackage

// File: rtl/rtc_time_stage.sv
module rtc_time_stage
  import bcd_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance_i,
  input  logic       ld_sec_i,
  input  logic       ld_min_i,
  input  logic       ld_hour_i,
  input  logic [7:0] ld_sec_val_i,
  input  logic [7:0] ld_min_val_i,
  input  logic [7:0] ld_hour_val_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       day_carry_o
);

  logic       sec_carry;
  logic       min_carry;
  logic       mode24;
  logic       last_hour;
  logic [7:0] hour_next;

  assign mode24    = hour_o[7];
  assign sec_carry = advance_i && (bcd_to_bin(sec_o) >= 8'd59);
  assign min_carry = sec_carry && (bcd_to_bin(min_o) >= 8'd59);

  always_comb begin
    if (mode24) begin
      last_hour = bcd_to_bin({2'b00, hour_o[5:0]}) >= 8'd23;
      hour_next = hour24_next(hour_o);
    end else begin
      last_hour = hour_o[5] && (bcd_to_bin({3'b000, hour_o[4:0]}) == 8'd11);
      hour_next = hour12_next(hour_o);
    end
  end

  assign day_carry_o = min_carry && last_hour;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_o  <= 8'h00;
      min_o  <= 8'h00;
      hour_o <= 8'h00;
    end else begin
      if (ld_sec_i)       sec_o <= ld_sec_val_i;
      else if (advance_i) sec_o <= bcd_step(sec_o, 8'd59, 8'd0);

      if (ld_min_i)       min_o <= ld_min_val_i;
      else if (sec_carry) min_o <= bcd_step(min_o, 8'd59, 8'd0);

      if (ld_hour_i)      hour_o <= ld_hour_val_i;
      else if (min_carry) hour_o <= hour_next;
    end
  end

endmodule

// File: rtl/rtc_calendar_stage.sv
module rtc_calendar_stage
  import bcd_rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry_i,
  input  logic       ld_date_i,
  input  logic       ld_month_i,
  input  logic       ld_year_i,
  input  logic       ld_wday_i,
  input  logic [7:0] ld_date_val_i,
  input  logic [7:0] ld_month_val_i,
  input  logic [7:0] ld_year_val_i,
  input  logic [7:0] ld_wday_val_i,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [7:0] wday_o
);

  logic [7:0] last_day;
  logic       date_carry;
  logic       month_carry;

  assign last_day    = month_days(month_o, year_o);
  assign date_carry  = day_carry_i && (bcd_to_bin(date_o) >= last_day);
  assign month_carry = date_carry && (bcd_to_bin(month_o) >= 8'd12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      date_o  <= 8'h01;
      month_o <= 8'h01;
      year_o  <= 8'h00;
      wday_o  <= 8'h00;
    end else begin
      if (ld_date_i)        date_o <= ld_date_val_i;
      else if (day_carry_i) date_o <= bcd_step(date_o, last_day, 8'd1);

      if (ld_month_i)       month_o <= ld_month_val_i;
      else if (date_carry)  month_o <= bcd_step(month_o, 8'd12, 8'd1);

      if (ld_year_i)        year_o <= ld_year_val_i;
      else if (month_carry) year_o <= bcd_step(year_o, 8'd99, 8'd0);

      if (ld_wday_i)        wday_o <= ld_wday_val_i;
      else if (day_carry_i) wday_o <= (wday_o >= 8'd6) ? 8'd0 : wday_o + 8'd1;
    end
  end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import bcd_rtc_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int REG_W    = BYTE_W,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ld_stb_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [REG_W-1:0] ld_data_i,
  output logic [REG_W-1:0] sec_o,
  output logic [REG_W-1:0] min_o,
  output logic [REG_W-1:0] hour_o,
  output logic [REG_W-1:0] date_o,
  output logic [REG_W-1:0] month_o,
  output logic [REG_W-1:0] year_o,
  output logic [REG_W-1:0] wday_o
);

  logic [NUM_REGS-1:0] ld_hit;
  logic [REG_W-1:0]    ld_val [NUM_REGS];
  logic                advance;
  logic                day_carry;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_load
    assign ld_hit[g] = ld_stb_i && (ld_idx_i == IDX_W'(g));
    assign ld_val[g] = ld_data_i & write_mask(g);
  end

  // A load cycle swallows the tick for every register.
  assign advance = tick_i && !ld_stb_i;

  rtc_time_stage u_time (
    .clk           (clk),
    .rst_n         (rst_n),
    .advance_i     (advance),
    .ld_sec_i      (ld_hit[IDX_SEC]),
    .ld_min_i      (ld_hit[IDX_MIN]),
    .ld_hour_i     (ld_hit[IDX_HOUR]),
    .ld_sec_val_i  (ld_val[IDX_SEC]),
    .ld_min_val_i  (ld_val[IDX_MIN]),
    .ld_hour_val_i (ld_val[IDX_HOUR]),
    .sec_o         (sec_o),
    .min_o         (min_o),
    .hour_o        (hour_o),
    .day_carry_o   (day_carry)
  );

  rtc_calendar_stage u_cal (
    .clk            (clk),
    .rst_n          (rst_n),
    .day_carry_i    (day_carry),
    .ld_date_i      (ld_hit[IDX_DATE]),
    .ld_month_i     (ld_hit[IDX_MONTH]),
    .ld_year_i      (ld_hit[IDX_YEAR]),
    .ld_wday_i      (ld_hit[IDX_WDAY]),
    .ld_date_val_i  (ld_val[IDX_DATE]),
    .ld_month_val_i (ld_val[IDX_MONTH]),
    .ld_year_val_i  (ld_val[IDX_YEAR]),
    .ld_wday_val_i  (ld_val[IDX_WDAY]),
    .date_o         (date_o),
    .month_o        (month_o),
    .year_o         (year_o),
    .wday_o         (wday_o)
  );

endmodule

// File: rtl/bcd_rtc_checker.sv
module bcd_rtc_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             ld_stb_i,
  input logic [IDX_W-1:0] ld_idx_i,
  input logic [7:0]       ld_data_i,
  input logic [7:0]       sec_o,
  input logic [7:0]       min_o,
  input logic [7:0]       hour_o,
  input logic [7:0]       date_o,
  input logic [7:0]       month_o,
  input logic [7:0]       year_o,
  input logic [7:0]       wday_o,
  input logic             day_carry
);

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] == 1'b0) && (min_o[7] == 1'b0) && (hour_o[6] == 1'b0) &&
    (date_o[7:6] == 2'b00) && (month_o[7:5] == 3'b000) && (wday_o[7:3] == 5'b0));

  assert_load_sec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb_i && ld_idx_i == IDX_W'(0)) |=> (sec_o == ($past(ld_data_i) & 8'h7F)));

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ld_stb_i && sec_o == 8'h59) |=> (sec_o == 8'h00));

  assert_tick_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb_i && ld_idx_i != IDX_W'(0)) |=> $stable(sec_o));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ld_stb_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                                $stable(date_o) && $stable(month_o) && $stable(year_o) &&
                                $stable(wday_o)));

  assert_mode_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_stb_i && ld_idx_i == IDX_W'(2)) |=> $stable(hour_o[7]));

  assert_wday_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_stb_i |=> ($stable(wday_o) || $past(day_carry)));

endmodule

bind bcd_rtc_core bcd_rtc_checker #(.IDX_W(IDX_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .ld_stb_i  (ld_stb_i),
  .ld_idx_i  (ld_idx_i),
  .ld_data_i (ld_data_i),
  .sec_o     (sec_o),
  .min_o     (min_o),
  .hour_o    (hour_o),
  .date_o    (date_o),
  .month_o   (month_o),
  .year_o    (year_o),
  .wday_o    (wday_o),
  .day_carry (day_carry)
);

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       ld_stb_i = 1'b0;
  logic [2:0] ld_idx_i = 3'd0;
  logic [7:0] ld_data_i = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o, wday_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bcd_rtc_core uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ld_stb_i(ld_stb_i),
    .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
    .month_o(month_o), .year_o(year_o), .wday_o(wday_o)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] idx, input logic [7:0] data);
    @(negedge clk);
    ld_stb_i  = 1'b1;
    ld_idx_i  = idx;
    ld_data_i = data;
    tick_i    = 1'b0;
    @(negedge clk);
    ld_stb_i  = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] s, m, h, d, mo, y, w);
    load(3'd0, s); load(3'd1, m); load(3'd2, h); load(3'd3, d);
    load(3'd4, mo); load(3'd5, y); load(3'd6, w);
  endtask

  task automatic t_reset();
    check("R1", "sec",   sec_o,   8'h00);
    check("R1", "min",   min_o,   8'h00);
    check("R1", "hour",  hour_o,  8'h00);
    check("R1", "date",  date_o,  8'h01);
    check("R1", "month", month_o, 8'h01);
    check("R1", "year",  year_o,  8'h00);
    check("R1", "wday",  wday_o,  8'h00);
  endtask

  task automatic t_seconds();
    set_all(8'h09, 8'h12, 8'h85, 8'h10, 8'h03, 8'h21, 8'h02);
    tick1();
    check("R2", "sec bcd step", sec_o, 8'h10);
    load(3'd0, 8'h59);
    tick1();
    check("R2", "sec wrap", sec_o, 8'h00);
    check("R2", "min carry", min_o, 8'h13);
    load(3'd0, 8'h59); load(3'd1, 8'h59);
    tick1();
    check("R2", "min wrap", min_o, 8'h00);
    check("R2", "hour carry", hour_o, 8'h86);
  endtask

  task automatic t_hour24();
    set_all(8'h59, 8'h59, 8'hA3, 8'h15, 8'h03, 8'h21, 8'h03);
    tick1();
    check("R3", "23 wraps", hour_o, 8'h80);
    check("R3", "new day date", date_o, 8'h16);
    check("R8", "wday step", wday_o, 8'h04);
    load(3'd0, 8'h59); load(3'd1, 8'h59); load(3'd2, 8'h89);
    tick1();
    check("R3", "09 to 10", hour_o, 8'h90);
    check("R3", "no day", date_o, 8'h16);
  endtask

  task automatic t_hour12();
    set_all(8'h59, 8'h59, 8'h11, 8'h10, 8'h06, 8'h21, 8'h01);
    tick1();
    check("R4", "11AM to 12PM", hour_o, 8'h32);
    check("R4", "no day at noon", date_o, 8'h10);
    load(3'd0, 8'h59); load(3'd1, 8'h59);
    tick1();
    check("R4", "12PM to 01PM", hour_o, 8'h21);
    load(3'd0, 8'h59); load(3'd1, 8'h59); load(3'd2, 8'h31);
    tick1();
    check("R4", "11PM to 12AM", hour_o, 8'h12);
    check("R4", "midnight date", date_o, 8'h11);
    check("R4", "midnight wday", wday_o, 8'h02);
  endtask

  task automatic end_of_day(input logic [7:0] d, mo, y);
    set_all(8'h59, 8'h59, 8'hA3, d, mo, y, 8'h00);
    tick1();
  endtask

  task automatic t_months();
    end_of_day(8'h30, 8'h04, 8'h21);
    check("R5", "Apr 30 date", date_o, 8'h01);
    check("R5", "Apr 30 month", month_o, 8'h05);
    end_of_day(8'h30, 8'h05, 8'h21);
    check("R5", "May 30 date", date_o, 8'h31);
    end_of_day(8'h31, 8'h08, 8'h21);
    check("R5", "Aug 31 month", month_o, 8'h09);
    end_of_day(8'h30, 8'h11, 8'h21);
    check("R5", "Nov 30 month", month_o, 8'h12);
  endtask

  task automatic t_february();
    end_of_day(8'h28, 8'h02, 8'h24);
    check("R6", "leap 28 to 29", date_o, 8'h29);
    load(3'd0, 8'h59); load(3'd1, 8'h59); load(3'd2, 8'hA3);
    tick1();
    check("R6", "leap 29 date", date_o, 8'h01);
    check("R6", "leap 29 month", month_o, 8'h03);
    end_of_day(8'h28, 8'h02, 8'h23);
    check("R6", "common 28 date", date_o, 8'h01);
    check("R6", "common 28 month", month_o, 8'h03);
    end_of_day(8'h28, 8'h02, 8'h00);
    check("R6", "year 00 leap", date_o, 8'h29);
  endtask

  task automatic t_year();
    end_of_day(8'h31, 8'h12, 8'h19);
    check("R7", "month wrap", month_o, 8'h01);
    check("R7", "year bcd step", year_o, 8'h20);
    end_of_day(8'h31, 8'h12, 8'h99);
    check("R7", "year 99 wrap", year_o, 8'h00);
    check("R7", "date after wrap", date_o, 8'h01);
  endtask

  task automatic t_wday();
    set_all(8'h59, 8'h59, 8'hA3, 8'h05, 8'h07, 8'h21, 8'h06);
    tick1();
    check("R8", "wday 6 to 0", wday_o, 8'h00);
  endtask

  task automatic t_masks();
    load(3'd0, 8'hFF); check("R9", "sec mask",   sec_o,   8'h7F);
    load(3'd1, 8'hC5); check("R9", "min mask",   min_o,   8'h45);
    load(3'd2, 8'hFF); check("R9", "hour mask",  hour_o,  8'hBF);
    load(3'd3, 8'hFF); check("R9", "date mask",  date_o,  8'h3F);
    load(3'd4, 8'hFF); check("R9", "month mask", month_o, 8'h1F);
    load(3'd5, 8'hFF); check("R9", "year mask",  year_o,  8'hFF);
    load(3'd6, 8'hFF); check("R9", "wday mask",  wday_o,  8'h07);
  endtask

  task automatic t_tick_in_load();
    set_all(8'h20, 8'h10, 8'h85, 8'h10, 8'h03, 8'h21, 8'h02);
    @(negedge clk);
    ld_stb_i = 1'b1; ld_idx_i = 3'd1; ld_data_i = 8'h33; tick_i = 1'b1;
    @(negedge clk);
    ld_stb_i = 1'b0; tick_i = 1'b0;
    check("R10", "sec unmoved", sec_o, 8'h20);
    check("R10", "min loaded", min_o, 8'h33);
    load(3'd0, 8'h59);
    @(negedge clk);
    ld_stb_i = 1'b1; ld_idx_i = 3'd6; ld_data_i = 8'h04; tick_i = 1'b1;
    @(negedge clk);
    ld_stb_i = 1'b0; tick_i = 1'b0;
    check("R10", "no wrap at 59", sec_o, 8'h59);
    check("R10", "min no carry", min_o, 8'h33);
  endtask

  task automatic t_hold();
    repeat (5) @(negedge clk);
    check("R11", "sec hold",  sec_o,  8'h59);
    check("R11", "min hold",  min_o,  8'h33);
    check("R11", "hour hold", hour_o, 8'h85);
    check("R11", "wday hold", wday_o, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seconds();
    t_hour24();
    t_hour12();
    t_months();
    t_february();
    t_year();
    t_wday();
    t_masks();
    t_tick_in_load();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule